// File: doc/BRIEF.md
# Linked-Descriptor Receive DMA

This block writes received frames into system memory by following a singly linked chain of 32-byte descriptors. Software builds the chain. It gives each descriptor to the engine by setting an ownership bit and a buffer size. It then loads a two-register start pointer. The engine reads one descriptor at a time over a 32-bit word port with a ready handshake. It checks ownership and packs incoming frame bytes into little-endian words inside the buffer. When the frame or the buffer ends, it writes back the byte count and a status word. Clearing the ownership bit in that status word returns the descriptor to software.

A frame that does not fit in one buffer continues in the next descriptor. Start-of-frame is marked only in the first descriptor of the frame. End-of-frame and the error flags are marked only in the last. If the engine reaches a descriptor it does not own, it halts and discards frames until software restarts it. After it has used the descriptor marked as the end of the chain, it goes idle.

Top module: `rxd_engine`

## Requirements
- R1: A write to the pointer-high register with bit 31 set, while the engine is idle or halted, starts it at the address last written to the pointer-low register. A pointer-high write with bit 31 clear does not start it. Descriptor words are fetched from byte offsets 0 (buffer address), 8 (next pointer), 12 (next-high word) and 20 (control/status).
- R2: If bit 15 (owner) of the fetched control/status word is 0, the engine halts and makes no memory write. While halted it accepts and discards incoming bytes and pulses `rx_drop` once per frame start. A new start (R1) resumes it.
- R3: Stored bytes are packed little-endian: the first byte of a word goes to bits 7:0. Each word is written to buffer address plus byte offset rounded down to 4, with byte enables covering only the bytes received. Buffer addresses are 4-byte aligned.
- R4: The count word at offset 16 holds the bytes stored in that buffer in bits 15:0. Bits 31:16 hold the VLAN tag when the descriptor ends a frame whose VLAN flag was set, and 0 otherwise.
- R5: The status word at offset 20 is written after the count word. Its bit 15 is 0, bits 31:16 keep the buffer size, bit 1 marks start of frame and bit 0 marks end of frame.
- R6: A frame longer than its buffer continues in the following descriptor. The start bit appears only in the first descriptor of the frame. The end bit and all error bits appear only in its last descriptor.
- R7: The CRC-error input (status bit 12), bad-frame input (bit 8) and VLAN-found input (bit 2) are sampled with the end-of-frame byte.
- R8: Status bit 4 (short) is set when the stored frame is shorter than MIN_FRAME bytes.
- R9: Bytes beyond MAX_FRAME in one frame are not stored, and status bit 11 is set.
- R10: After it writes back a descriptor whose next-high word has bit 31 set, the engine goes idle (`q_running` low) and discards frames. Otherwise it fetches the descriptor at the next pointer.
- R11: A start write made while the engine is running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ptr_lo_we | input | 1 | Write strobe for the pointer-low register |
| ptr_hi_we | input | 1 | Write strobe for the pointer-high register (bit 31 = start) |
| ptr_wdata | input | 32 | Data for pointer writes |
| q_running | output | 1 | Engine is walking the chain (neither idle nor halted) |
| rx_valid | input | 1 | Frame byte present |
| rx_ready | output | 1 | Byte accepted this cycle |
| rx_data | input | 8 | Frame byte |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_crc_err | input | 1 | CRC error, valid with rx_eof |
| rx_bad | input | 1 | Bad frame, valid with rx_eof |
| rx_vlan_hit | input | 1 | VLAN tag found, valid with rx_eof |
| rx_vlan_tag | input | 16 | VLAN tag, valid with rx_eof |
| rx_drop | output | 1 | A frame start was discarded |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access completes this cycle |

## Verification
The test drives a short frame into one large buffer. This shows single-descriptor handling, partial-word byte enables and the short flag. A 70-byte frame across two 40-byte buffers with a CRC error and a VLAN tag shows how start, end and error bits are split between descriptors. An unowned descriptor followed by a restart, and an over-long frame with a start attempt made mid-run, separate halting, the length limit and ignored restarts. Frames offered after the end of the chain show that the engine idles and drops them.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_DATA, ST_WORD, ST_WBC, ST_WBS, ST_STOP
    } rxd_state_e;

    localparam int OWN_BIT   = 15;
    localparam int LAST_BIT  = 31;
    localparam int START_BIT = 31;

    localparam int FLG_EOF    = 0;
    localparam int FLG_SOF    = 1;
    localparam int FLG_VLAN   = 2;
    localparam int FLG_SHORT  = 4;
    localparam int FLG_BAD    = 8;
    localparam int FLG_MAXLEN = 11;
    localparam int FLG_CRC    = 12;

    localparam logic [4:0] OFF_CNT = 5'd16;
    localparam logic [4:0] OFF_STS = 5'd20;

    typedef struct packed {
        logic crc;
        logic bad;
        logic vlan;
        logic maxlen;
        logic short_f;
    } rxd_err_t;

    function automatic logic [4:0] fetch_off(input logic [1:0] idx);
        case (idx)
            2'd0:    return 5'd0;
            2'd1:    return 5'd8;
            2'd2:    return 5'd12;
            default: return 5'd20;
        endcase
    endfunction
endpackage

// File: rtl/rxd_packer.sv
module rxd_packer #(
    parameter int DW = 32,
    localparam int NB = DW / 8,
    localparam int LW = $clog2(NB)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          byte_we,
    input  logic [LW-1:0] lane,
    input  logic [7:0]    byte_in,
    input  logic          clr,
    output logic [DW-1:0] word,
    output logic [NB-1:0] be
);
    typedef struct packed {
        logic [DW-1:0] word;
        logic [NB-1:0] be;
    } pk_t;

    pk_t pk_d, pk_q;

    always_comb begin
        pk_d = pk_q;
        if (clr) begin
            pk_d.be = '0;
        end
        for (int i = 0; i < NB; i++) begin
            if (byte_we && lane == LW'(i)) begin
                pk_d.word[i*8 +: 8] = byte_in;
                pk_d.be[i]          = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pk_q <= '0;
        else        pk_q <= pk_d;
    end

    assign word = pk_q.word;
    assign be   = pk_q.be;

    // R3: a lane is never filled twice before the word is written out
    p_lane_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
        byte_we |-> !pk_q.be[lane]);
endmodule

// File: rtl/rxd_wb_fmt.sv
module rxd_wb_fmt
    import rxd_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic [LEN_W-1:0] bcnt,
    input  logic [LEN_W-1:0] bsize,
    input  logic             first,
    input  logic             frame_end,
    input  rxd_err_t         err,
    input  logic [15:0]      vtag,
    output logic [31:0]      cnt_word,
    output logic [31:0]      sts_word
);
    logic [15:0] flags;

    always_comb begin
        flags = '0;
        flags[FLG_SOF] = first;
        flags[FLG_EOF] = frame_end;
        if (frame_end) begin
            flags[FLG_VLAN]   = err.vlan;
            flags[FLG_SHORT]  = err.short_f;
            flags[FLG_BAD]    = err.bad;
            flags[FLG_MAXLEN] = err.maxlen;
            flags[FLG_CRC]    = err.crc;
        end
        sts_word = {16'(bsize), flags};
        cnt_word = {(frame_end && err.vlan) ? vtag : 16'd0, 16'(bcnt)};
    end
endmodule

// File: rtl/rxd_engine.sv
module rxd_engine
    import rxd_pkg::*;
#(
    parameter int MIN_FRAME = 64,
    parameter int MAX_FRAME = 1518,
    parameter int LEN_W     = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ptr_lo_we,
    input  logic        ptr_hi_we,
    input  logic [31:0] ptr_wdata,
    output logic        q_running,
    input  logic        rx_valid,
    output logic        rx_ready,
    input  logic [7:0]  rx_data,
    input  logic        rx_sof,
    input  logic        rx_eof,
    input  logic        rx_crc_err,
    input  logic        rx_bad,
    input  logic        rx_vlan_hit,
    input  logic [15:0] rx_vlan_tag,
    output logic        rx_drop,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [3:0]  mem_be,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    input  logic        mem_ready
);
    localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_FRAME);
    localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_FRAME);

    typedef struct packed {
        rxd_state_e       st;
        logic [1:0]       fidx;
        logic [31:0]      desc;
        logic [31:0]      buf_a;
        logic [31:0]      nxt;
        logic [31:0]      ptr_lo;
        logic             last;
        logic [LEN_W-1:0] bsize;
        logic [LEN_W-1:0] bcnt;
        logic [LEN_W-1:0] flen;
        logic [15:0]      vtag;
        logic             in_frame;
        logic             first;
        logic             eof_seen;
        rxd_err_t         err;
    } regs_t;

    regs_t r_d, r_q;

    logic             pk_we, pk_clr;
    logic [31:0]      pk_word;
    logic [3:0]       pk_be;
    logic [31:0]      wb_cnt, wb_sts;
    logic             start;
    logic             store;
    logic [LEN_W-1:0] fl_base, fl_new, widx;
    rxd_err_t         errs;

    rxd_packer #(.DW(32)) u_pack (
        .clk     (clk),
        .rst_n   (rst_n),
        .byte_we (pk_we),
        .lane    (r_q.bcnt[1:0]),
        .byte_in (rx_data),
        .clr     (pk_clr),
        .word    (pk_word),
        .be      (pk_be)
    );

    rxd_wb_fmt #(.LEN_W(LEN_W)) u_fmt (
        .bcnt      (r_q.bcnt),
        .bsize     (r_q.bsize),
        .first     (r_q.first),
        .frame_end (r_q.eof_seen),
        .err       (r_q.err),
        .vtag      (r_q.vtag),
        .cnt_word  (wb_cnt),
        .sts_word  (wb_sts)
    );

    always_comb begin
        r_d       = r_q;
        pk_we     = 1'b0;
        pk_clr    = 1'b0;
        rx_ready  = 1'b0;
        rx_drop   = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_be    = '0;
        mem_wdata = '0;
        store     = 1'b0;
        fl_base   = '0;
        fl_new    = '0;
        errs      = r_q.err;
        widx      = r_q.bcnt - LEN_W'(1);
        start     = ptr_hi_we && ptr_wdata[START_BIT] &&
                    (r_q.st == ST_IDLE || r_q.st == ST_STOP);

        if (ptr_lo_we) r_d.ptr_lo = ptr_wdata;

        case (r_q.st)
            ST_IDLE, ST_STOP: begin
                rx_ready     = 1'b1;
                rx_drop      = rx_valid && rx_sof;
                r_d.in_frame = 1'b0;
                if (start) begin
                    r_d.st       = ST_FETCH;
                    r_d.fidx     = '0;
                    r_d.desc     = r_q.ptr_lo;
                    r_d.bcnt     = '0;
                    r_d.first    = 1'b0;
                    r_d.eof_seen = 1'b0;
                    r_d.err      = '0;
                end
            end
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = r_q.desc + {27'd0, fetch_off(r_q.fidx)};
                if (mem_ready) begin
                    r_d.fidx = r_q.fidx + 2'd1;
                    case (r_q.fidx)
                        2'd0: r_d.buf_a = mem_rdata;
                        2'd1: r_d.nxt   = mem_rdata;
                        2'd2: r_d.last  = mem_rdata[LAST_BIT];
                        default: begin
                            if (mem_rdata[OWN_BIT]) begin
                                r_d.bsize = LEN_W'(mem_rdata[31:16]);
                                r_d.st    = ST_DATA;
                            end else begin
                                r_d.st       = ST_STOP;
                                r_d.in_frame = 1'b0;
                            end
                        end
                    endcase
                end
            end
            ST_DATA: begin
                rx_ready = 1'b1;
                if (rx_valid && (rx_sof || r_q.in_frame)) begin
                    fl_base = rx_sof ? '0 : r_q.flen;
                    if (rx_sof) begin
                        r_d.in_frame = 1'b1;
                        r_d.first    = 1'b1;
                        errs         = '0;
                    end
                    store = fl_base < MAX_L;
                    if (store) begin
                        pk_we    = 1'b1;
                        r_d.bcnt = r_q.bcnt + LEN_W'(1);
                        fl_new   = fl_base + LEN_W'(1);
                    end else begin
                        fl_new      = fl_base;
                        errs.maxlen = 1'b1;
                    end
                    r_d.flen = fl_new;
                    if (rx_eof) begin
                        r_d.eof_seen = 1'b1;
                        errs.crc     = rx_crc_err;
                        errs.bad     = rx_bad;
                        errs.vlan    = rx_vlan_hit;
                        errs.short_f = fl_new < MIN_L;
                        r_d.vtag     = rx_vlan_tag;
                    end
                    r_d.err = errs;
                    if (rx_eof || (store && (r_q.bcnt + LEN_W'(1) == r_q.bsize)) ||
                        (store && r_q.bcnt[1:0] == 2'd3)) begin
                        r_d.st = (store || (|pk_be)) ? ST_WORD : ST_WBC;
                    end
                end
            end
            ST_WORD: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = r_q.buf_a + 32'({widx[LEN_W-1:2], 2'b00});
                mem_wdata = pk_word;
                mem_be    = pk_be;
                if (mem_ready) begin
                    pk_clr = 1'b1;
                    r_d.st = (r_q.eof_seen || r_q.bcnt == r_q.bsize) ? ST_WBC : ST_DATA;
                end
            end
            ST_WBC: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = r_q.desc + {27'd0, OFF_CNT};
                mem_wdata = wb_cnt;
                mem_be    = 4'hF;
                if (mem_ready) r_d.st = ST_WBS;
            end
            ST_WBS: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = r_q.desc + {27'd0, OFF_STS};
                mem_wdata = wb_sts;
                mem_be    = 4'hF;
                if (mem_ready) begin
                    if (r_q.eof_seen) begin
                        r_d.in_frame = 1'b0;
                        r_d.eof_seen = 1'b0;
                    end
                    r_d.first = 1'b0;
                    r_d.bcnt  = '0;
                    if (r_q.last) begin
                        r_d.st = ST_IDLE;
                    end else begin
                        r_d.st   = ST_FETCH;
                        r_d.fidx = '0;
                        r_d.desc = r_q.nxt;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign q_running = (r_q.st != ST_IDLE) && (r_q.st != ST_STOP);

    // R1: a pending access holds its address and direction until accepted
    p_req_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R3: every access is word aligned and writes carry at least one lane
    p_addr_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[1:0] == 2'b00);
    p_be_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> mem_be != 4'h0);

    // R2: a halted engine makes no memory access
    p_stop_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.st == ST_STOP |-> !mem_req);

    // R5: the status writeback returns ownership to software
    p_owner_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.st == ST_WBS && mem_req |-> !mem_wdata[OWN_BIT]);

    // R5: status is only written right after the count word
    p_sts_after_cnt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.st == ST_WBC && mem_ready |=> r_q.st == ST_WBS);

    // R6: a buffer that does not end its frame carries no end or error bits
    p_mid_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.st == ST_WBS && !r_q.eof_seen |->
            !mem_wdata[FLG_EOF] && !mem_wdata[FLG_CRC] && !mem_wdata[FLG_BAD]);
endmodule

// File: tb/tb_rxd_engine.sv
module tb_rxd_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ptr_lo_we = 1'b0, ptr_hi_we = 1'b0;
    logic [31:0] ptr_wdata = '0;
    logic        q_running;
    logic        rx_valid = 1'b0, rx_ready;
    logic [7:0]  rx_data = '0;
    logic        rx_sof = 1'b0, rx_eof = 1'b0;
    logic        rx_crc_err = 1'b0, rx_bad = 1'b0, rx_vlan_hit = 1'b0;
    logic [15:0] rx_vlan_tag = '0;
    logic        rx_drop;
    logic        mem_req, mem_we, mem_ready = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0]  mem_be;

    logic [31:0] mem [0:1023];
    int checks = 0, fails = 0;
    int n_rd = 0, n_wr = 0, n_drop = 0, n_req = 0, rdy_cnt = 0;

    always #5 clk = ~clk;

    rxd_engine #(.MIN_FRAME(64), .MAX_FRAME(100)) dut (
        .clk(clk), .rst_n(rst_n), .ptr_lo_we(ptr_lo_we), .ptr_hi_we(ptr_hi_we),
        .ptr_wdata(ptr_wdata), .q_running(q_running), .rx_valid(rx_valid),
        .rx_ready(rx_ready), .rx_data(rx_data), .rx_sof(rx_sof), .rx_eof(rx_eof),
        .rx_crc_err(rx_crc_err), .rx_bad(rx_bad), .rx_vlan_hit(rx_vlan_hit),
        .rx_vlan_tag(rx_vlan_tag), .rx_drop(rx_drop), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    assign mem_rdata = mem[mem_addr[11:2]];

    always @(negedge clk) begin
        rdy_cnt   <= rdy_cnt + 1;
        mem_ready <= (rdy_cnt % 3) != 0;
    end

    always @(posedge clk) begin
        if (rst_n) begin
            if (mem_req) n_req++;
            if (rx_drop) n_drop++;
            if (mem_req && mem_ready && !mem_we) n_rd++;
            if (mem_req && mem_ready && mem_we) begin
                n_wr++;
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) mem[mem_addr[11:2]][b*8 +: 8] = mem_wdata[b*8 +: 8];
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic mk_desc(input int a, input int bufa, input int nxt, input bit last,
                           input bit own, input int size);
        mem[a/4 + 0] = bufa;
        mem[a/4 + 1] = 0;
        mem[a/4 + 2] = nxt;
        mem[a/4 + 3] = {last, 31'd0};
        mem[a/4 + 4] = 0;
        mem[a/4 + 5] = (size << 16) | (int'(own) << 15);
        mem[a/4 + 6] = 0;
        mem[a/4 + 7] = 0;
        for (int w = 0; w < 48; w++) mem[bufa/4 + w] = 32'hEEEE_EEEE;
    endtask

    task automatic wr_ptr(input bit hi, input logic [31:0] v);
        @(negedge clk);
        ptr_wdata = v;
        ptr_lo_we = !hi;
        ptr_hi_we = hi;
        @(negedge clk);
        ptr_lo_we = 1'b0;
        ptr_hi_we = 1'b0;
    endtask

    task automatic send(input int n, input logic [7:0] base, input bit crc, input bit bad,
                        input bit vh, input logic [15:0] tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid    = 1'b1;
            rx_data     = base + 8'(i);
            rx_sof      = (i == 0);
            rx_eof      = (i == n - 1);
            rx_crc_err  = crc;
            rx_bad      = bad;
            rx_vlan_hit = vh;
            rx_vlan_tag = tag;
            while (!rx_ready) @(negedge clk);
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_sof   = 1'b0;
        rx_eof   = 1'b0;
    endtask

    function automatic logic [31:0] exp_word(input logic [7:0] base, input int first_idx,
                                             input int n);
        logic [31:0] w;
        for (int b = 0; b < 4; b++)
            w[b*8 +: 8] = (first_idx + b < n) ? base + 8'(first_idx + b) : 8'hEE;
        return w;
    endfunction

    task automatic t_reset;
        @(negedge clk);
        chk("R10 reset idle", {31'd0, q_running}, 32'd0);
        chk("R1 reset no request", {31'd0, mem_req}, 32'd0);
        chk("R2 reset accepts bytes", {31'd0, rx_ready}, 32'd1);
    endtask

    task automatic t_start;
        mk_desc(32'h100, 32'h400, 32'h120, 1'b0, 1'b1, 64);
        mk_desc(32'h120, 32'h500, 32'h140, 1'b0, 1'b1, 40);
        mk_desc(32'h140, 32'h600, 32'h000, 1'b1, 1'b1, 40);
        wr_ptr(1'b0, 32'h100);
        wr_ptr(1'b1, 32'h0000_0001);
        repeat (20) @(negedge clk);
        chk("R1 no start without valid bit", n_req, 0);
        wr_ptr(1'b1, 32'h8000_0000);
        repeat (20) @(negedge clk);
        chk("R1 four descriptor reads", n_rd, 4);
        chk("R1 running after start", {31'd0, q_running}, 32'd1);
    endtask

    task automatic t_short;
        send(10, 8'h10, 1'b0, 1'b0, 1'b0, 16'h0);
        repeat (60) @(negedge clk);
        chk("R3 word 0", mem[32'h400/4], exp_word(8'h10, 0, 10));
        chk("R3 partial word", mem[32'h408/4], exp_word(8'h10, 8, 10));
        chk("R3 untouched word", mem[32'h40C/4], 32'hEEEE_EEEE);
        chk("R4 count single", mem[32'h110/4], 32'd10);
        chk("R8 R5 status single", mem[32'h114/4], 32'h0040_0013);
    endtask

    task automatic t_span;
        send(70, 8'h40, 1'b1, 1'b0, 1'b1, 16'hABCD);
        repeat (100) @(negedge clk);
        chk("R6 first buffer count", mem[32'h130/4], 32'd40);
        chk("R6 first buffer status", mem[32'h134/4], 32'h0028_0002);
        chk("R4 last count with tag", mem[32'h150/4], 32'hABCD_001E);
        chk("R7 last status", mem[32'h154/4], 32'h0028_1005);
        chk("R6 second buffer word 0", mem[32'h600/4], exp_word(8'h40, 40, 70));
        chk("R3 second buffer tail", mem[32'h61C/4], exp_word(8'h40, 68, 70));
        chk("R10 idle after last", {31'd0, q_running}, 32'd0);
        begin
            int w0 = n_wr;
            int d0 = n_drop;
            send(8, 8'h01, 1'b0, 1'b0, 1'b0, 16'h0);
            repeat (10) @(negedge clk);
            chk("R10 frame dropped when idle", n_drop - d0, 1);
            chk("R10 no write when idle", n_wr - w0, 0);
        end
    endtask

    task automatic t_unowned;
        int w0, d0;
        mk_desc(32'h180, 32'h700, 32'h000, 1'b1, 1'b0, 128);
        wr_ptr(1'b0, 32'h180);
        wr_ptr(1'b1, 32'h8000_0000);
        repeat (30) @(negedge clk);
        chk("R2 halted", {31'd0, q_running}, 32'd0);
        w0 = n_wr;
        d0 = n_drop;
        send(12, 8'h33, 1'b0, 1'b0, 1'b0, 16'h0);
        repeat (10) @(negedge clk);
        chk("R2 frame dropped", n_drop - d0, 1);
        chk("R2 no writes while halted", n_wr - w0, 0);
        chk("R2 descriptor still software owned", mem[32'h194/4], 32'h0080_0000);
    endtask

    task automatic t_maxlen;
        mem[32'h194/4] = 32'h0080_8000;
        wr_ptr(1'b1, 32'h8000_0000);
        repeat (30) @(negedge clk);
        chk("R2 resumed", {31'd0, q_running}, 32'd1);
        wr_ptr(1'b0, 32'h100);
        wr_ptr(1'b1, 32'h8000_0000);
        send(105, 8'h20, 1'b0, 1'b1, 1'b0, 16'h0);
        repeat (80) @(negedge clk);
        chk("R11 restart ignored, count in active descriptor", mem[32'h190/4], 32'd100);
        chk("R9 status length and bad", mem[32'h194/4], 32'h0080_0903);
        chk("R9 last stored word", mem[32'h760/4], exp_word(8'h20, 96, 100));
        chk("R9 excess bytes not stored", mem[32'h764/4], 32'hEEEE_EEEE);
        chk("R11 first chain untouched", mem[32'h110/4], 32'd10);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_start;
        t_short;
        t_span;
        t_unowned;
        t_maxlen;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #1_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule